// File: doc/BRIEF.md
# FIFO Trigger-Level and DMA Ready Signalling

This block sits beside the 64-entry transmit and receive FIFOs of one serial channel. It turns their fill counts into the threshold conditions that the interrupt logic consumes and into the active-low ready strobes that a DMA engine watches. The receive threshold counts stored characters. The transmit threshold counts free slots, not stored bytes.

The software-visible trigger register holds two 4-bit codes, one per direction. A nonzero code selects a level of four times its value, which gives 4 to 60. A zero code falls back to a fixed default level, chosen by a 2-bit select per direction that the surrounding FIFO control logic supplies. A mode input picks one of two ready behaviours:
- **Single-transfer mode**: the ready strobes follow the empty state of each FIFO.
- **Block-transfer mode**: the ready strobes follow the trigger levels, and the receive side holds its strobe until the FIFO drains.

A 2-bit ready vector mirrors both strobes, active-high, so that a status register shared by several channels can collect them in one read. Every output is registered.

Top module: `fifo_ready_sig`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `rxrdy_n`=1, `txrdy_n`=1, `rx_trig`=0, `tx_trig`=0 and `rdy_status`=0, and the block-mode receive hold is cleared.
- R2: When `trig_lvl_reg[7:4]` is a nonzero value n, the receive level is 4·n. `rx_trig` is 1 exactly when `rx_count` ≥ that level.
- R3: When `trig_lvl_reg[3:0]` is a nonzero value n, the transmit level is 4·n. `tx_trig` is 1 exactly when 64 − `tx_count` ≥ that level.
- R4: A zero nibble selects a default level. For the receive side, `rx_dflt_sel` values 0,1,2,3 give 8,16,56,60. For the transmit side, `tx_dflt_sel` values 0,1,2,3 give 8,16,32,56.
- R5: With `dma_multi`=0, `rxrdy_n` is 0 exactly when `rx_count` ≥ 1 and `rx_err_flag`=0.
- R6: With `dma_multi`=0, `txrdy_n` is 0 exactly when `tx_count` = 0.
- R7: With `dma_multi`=1, `rxrdy_n` goes to 0 when `rx_count` reaches the receive level. It stays 0 while `rx_count` is nonzero, even below the level, and returns to 1 when `rx_count` is 0.
- R8: With `dma_multi`=1, `txrdy_n` is 0 exactly when the free space 64 − `tx_count` is at least the transmit level.
- R9: `rx_err_flag`=1 forces `rxrdy_n` to 1 in either mode and clears the block-mode hold. After the flag drops, `rxrdy_n` returns to 0 in block mode only once the receive level is reached again.
- R10: `rdy_status[1]` equals the inverse of `rxrdy_n` and `rdy_status[0]` equals the inverse of `txrdy_n`, in every cycle.
- R11: Every output changes one clock after the inputs that cause it. A change of input between edges leaves the outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | 7 | Characters held in the receive FIFO (0..64) |
| tx_count | input | 7 | Characters held in the transmit FIFO (0..64) |
| trig_lvl_reg | input | 8 | [7:4] receive level code, [3:0] transmit level code |
| rx_dflt_sel | input | 2 | Default receive level select, used when the code is zero |
| tx_dflt_sel | input | 2 | Default transmit level select, used when the code is zero |
| rx_err_flag | input | 1 | An errored character is stored in the receive FIFO |
| dma_multi | input | 1 | 0 = single-transfer ready mode, 1 = block-transfer ready mode |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low |
| rx_trig | output | 1 | Receive count at or above the receive level |
| tx_trig | output | 1 | Free transmit space at or above the transmit level |
| rdy_status | output | 2 | {receive ready, transmit ready}, active high |

## Verification
The in-line assertions check the rules that hold on every cycle regardless of history:
- an error flag or an empty receive FIFO always blocks receive ready on the next edge;
- single-mode transmit ready follows the empty state;
- each decoded level stays a multiple of four within 4 to 60;
- each trigger output follows its threshold comparison one clock later.

The block-mode receive hold depends on the path taken to reach a count, so only the bench's ordered scenarios can show it. The same applies to the boundary counts exactly at and one below each level, and to the default-table values.

// File: rtl/fifo_rdy_pkg.sv
// Package: fifo_rdy_pkg
// Shared sizes and default trigger tables for the FIFO ready signalling block.
// Assumes FIFO counts never exceed FIFO_DEPTH.
package fifo_rdy_pkg;

    parameter int FIFO_DEPTH = 64;
    parameter int CODE_W     = 4;
    parameter int SEL_W      = 2;
    parameter int STEP_SHIFT = 2;   // level = code << STEP_SHIFT

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    // Default receive level for a zero code: characters stored.
    function automatic cnt_t rx_default(input logic [SEL_W-1:0] sel);
        cnt_t lvl;
        case (sel)
            2'd0:    lvl = cnt_t'(8);
            2'd1:    lvl = cnt_t'(16);
            2'd2:    lvl = cnt_t'(56);
            default: lvl = cnt_t'(60);
        endcase
        return lvl;
    endfunction

    // Default transmit level for a zero code: free slots.
    function automatic cnt_t tx_default(input logic [SEL_W-1:0] sel);
        cnt_t lvl;
        case (sel)
            2'd0:    lvl = cnt_t'(8);
            2'd1:    lvl = cnt_t'(16);
            2'd2:    lvl = cnt_t'(32);
            default: lvl = cnt_t'(56);
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rdy_level_decode.sv
// Module: rdy_level_decode
// Turns a 4-bit trigger code into a level in FIFO entries. A nonzero code
// gives code*4. A zero code picks a default level from the table that
// IS_RX selects. Purely combinational; the caller registers the results.
module rdy_level_decode
    import fifo_rdy_pkg::*;
#(
    parameter bit IS_RX = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic [SEL_W-1:0]  dflt_sel,
    output cnt_t              level
);

    localparam int LVL_MIN = 1 << STEP_SHIFT;
    localparam int LVL_MAX = ((1 << CODE_W) - 1) << STEP_SHIFT;

    cnt_t scaled;
    cnt_t dflt;

    // Scale a nonzero code by the step size.
    always_comb begin
        scaled = cnt_t'({code, {STEP_SHIFT{1'b0}}});
    end

    // Pick the default table for this direction.
    generate
        if (IS_RX) begin : g_rx_tbl
            always_comb dflt = rx_default(dflt_sel);
        end else begin : g_tx_tbl
            always_comb dflt = tx_default(dflt_sel);
        end
    endgenerate

    // Select the programmed or the default level.
    always_comb begin
        level = (code == '0) ? dflt : scaled;
    end

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level) >= LVL_MIN) && (int'(level) <= LVL_MAX) && (level[1:0] == 2'b00)) // R2
        else $error("decoded level out of range");

endmodule

// File: rtl/rdy_rx_path.sv
// Module: rdy_rx_path
// Receive-side threshold and ready strobe. The single mode tracks non-empty.
// The block mode sets on reaching the level and holds until the FIFO drains.
// A stored-error flag blocks the strobe and drops the hold.
// Assumes count <= FIFO_DEPTH and a level of at least 4.
module rdy_rx_path
    import fifo_rdy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t count,
    input  cnt_t level,
    input  logic err_flag,
    input  logic multi_mode,
    output logic rdy_n,
    output logic trig
);

    logic at_level;
    logic non_empty;
    logic hold_q;
    logic hold_d;
    logic ready_d;

    // Threshold comparisons against the current count.
    always_comb begin
        at_level  = (count >= level);
        non_empty = (count != '0);
    end

    // Block-mode hold: armed at the level, kept while data remains.
    always_comb begin
        hold_d = !err_flag && non_empty && (at_level || hold_q);
    end

    // Ready condition for the selected mode.
    always_comb begin
        if (err_flag) begin
            ready_d = 1'b0;
        end else if (multi_mode) begin
            ready_d = at_level || (hold_q && non_empty);
        end else begin
            ready_d = non_empty;
        end
    end

    // Register the hold, strobe and trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            rdy_n  <= 1'b1;
            trig   <= 1'b0;
        end else begin
            hold_q <= hold_d;
            rdy_n  <= !ready_d;
            trig   <= at_level;
        end
    end

    AST_RX_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> rdy_n) // R9
        else $error("receive ready active with error flagged");

    AST_RX_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> (rdy_n && !trig)) // R5
        else $error("receive ready active on empty FIFO");

    AST_RX_TRIG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= level) |=> trig) // R2
        else $error("receive trigger missed");

    AST_RX_MULTI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_mode && !err_flag && count >= level) |=> !rdy_n) // R7
        else $error("block-mode receive ready missed at level");

endmodule

// File: rtl/rdy_tx_path.sv
// Module: rdy_tx_path
// Transmit-side threshold on free space and the ready strobe. The single
// mode tracks the empty state. The block mode tracks free space against
// the level. Assumes count <= FIFO_DEPTH.
module rdy_tx_path
    import fifo_rdy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t count,
    input  cnt_t level,
    input  logic multi_mode,
    output logic rdy_n,
    output logic trig
);

    localparam cnt_t DEPTH_C = cnt_t'(FIFO_DEPTH);

    cnt_t free_slots;
    logic room_ok;
    logic ready_d;

    // Free space and its comparison with the level.
    always_comb begin
        free_slots = DEPTH_C - count;
        room_ok    = (free_slots >= level);
    end

    // Ready condition for the selected mode.
    always_comb begin
        ready_d = multi_mode ? room_ok : (count == '0);
    end

    // Register the strobe and trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
            trig  <= 1'b0;
        end else begin
            rdy_n <= !ready_d;
            trig  <= room_ok;
        end
    end

    AST_TX_SINGLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_mode && count == '0) |=> !rdy_n) // R6
        else $error("single-mode transmit ready missed on empty");

    AST_TX_SINGLE_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_mode && count != '0) |=> rdy_n) // R6
        else $error("single-mode transmit ready with data present");

    AST_TX_FULL_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (count == DEPTH_C) |=> !trig) // R3
        else $error("transmit trigger with full FIFO");

endmodule

// File: rtl/fifo_ready_sig.sv
// Module: fifo_ready_sig
// Top of the FIFO trigger and ready signalling block. Splits the trigger
// register into the two direction codes, decodes the levels and drives the
// registered strobes, triggers and the active-high ready vector.
// Assumes FIFO counts are synchronous to clk and within 0..FIFO_DEPTH.
module fifo_ready_sig
    import fifo_rdy_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       rx_count,
    input  logic [CNT_W-1:0]       tx_count,
    input  logic [2*CODE_W-1:0]    trig_lvl_reg,
    input  logic [SEL_W-1:0]       rx_dflt_sel,
    input  logic [SEL_W-1:0]       tx_dflt_sel,
    input  logic                   rx_err_flag,
    input  logic                   dma_multi,
    output logic                   rxrdy_n,
    output logic                   txrdy_n,
    output logic                   rx_trig,
    output logic                   tx_trig,
    output logic [1:0]             rdy_status
);

    cnt_t rx_level;
    cnt_t tx_level;

    // Receive level from the upper code.
    rdy_level_decode #(.IS_RX(1'b1)) u_rx_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (trig_lvl_reg[2*CODE_W-1:CODE_W]),
        .dflt_sel (rx_dflt_sel),
        .level    (rx_level)
    );

    // Transmit level from the lower code.
    rdy_level_decode #(.IS_RX(1'b0)) u_tx_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (trig_lvl_reg[CODE_W-1:0]),
        .dflt_sel (tx_dflt_sel),
        .level    (tx_level)
    );

    rdy_rx_path u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (rx_count),
        .level      (rx_level),
        .err_flag   (rx_err_flag),
        .multi_mode (dma_multi),
        .rdy_n      (rxrdy_n),
        .trig       (rx_trig)
    );

    rdy_tx_path u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (tx_count),
        .level      (tx_level),
        .multi_mode (dma_multi),
        .rdy_n      (txrdy_n),
        .trig       (tx_trig)
    );

    // Active-high ready vector for a shared multi-channel status read.
    always_comb begin
        rdy_status = {~rxrdy_n, ~txrdy_n};
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (rxrdy_n && txrdy_n && !rx_trig && !tx_trig)) // R1
        else $error("outputs not idle after reset");

endmodule

// File: tb/fifo_ready_sig_tb.sv
module fifo_ready_sig_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] rx_count = '0;
    logic [6:0] tx_count = '0;
    logic [7:0] trig_lvl_reg = '0;
    logic [1:0] rx_dflt_sel = '0;
    logic [1:0] tx_dflt_sel = '0;
    logic       rx_err_flag = 1'b0;
    logic       dma_multi = 1'b0;
    logic       rxrdy_n, txrdy_n, rx_trig, tx_trig;
    logic [1:0] rdy_status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    fifo_ready_sig u_dut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .trig_lvl_reg(trig_lvl_reg), .rx_dflt_sel(rx_dflt_sel),
        .tx_dflt_sel(tx_dflt_sel), .rx_err_flag(rx_err_flag),
        .dma_multi(dma_multi), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n),
        .rx_trig(rx_trig), .tx_trig(tx_trig), .rdy_status(rdy_status)
    );

    typedef struct packed {
        logic       mode;
        logic [7:0] trig;
        logic [1:0] rsel;
        logic [1:0] tsel;
        logic [6:0] rc;
        logic [6:0] tc;
        logic       err;
        logic       e_rxn;
        logic       e_txn;
        logic       e_rt;
        logic       e_tt;
    } vec_t;

    localparam int NV = 19;
    // Ordered: block-mode rows depend on the hold left by earlier rows.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 2'd0, 2'd0, 7'd0,  7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 R5 R6
        '{1'b0, 8'h21, 2'd0, 2'd0, 7'd1,  7'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 R6
        '{1'b0, 8'h21, 2'd0, 2'd0, 7'd8,  7'd60, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 R3 at level
        '{1'b0, 8'h21, 2'd0, 2'd0, 7'd7,  7'd61, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 R3 below
        '{1'b0, 8'h21, 2'd0, 2'd0, 7'd5,  7'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 single
        '{1'b0, 8'hFF, 2'd0, 2'd0, 7'd60, 7'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 R3 max
        '{1'b0, 8'hFF, 2'd0, 2'd0, 7'd59, 7'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 R3 max-1
        '{1'b0, 8'h00, 2'd3, 2'd2, 7'd60, 7'd32, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4
        '{1'b0, 8'h00, 2'd3, 2'd2, 7'd59, 7'd33, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
        '{1'b0, 8'h00, 2'd1, 2'd3, 7'd16, 7'd8,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4
        '{1'b0, 8'h00, 2'd2, 2'd1, 7'd55, 7'd48, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R4
        '{1'b1, 8'h30, 2'd0, 2'd0, 7'd0,  7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 R8 empty
        '{1'b1, 8'h30, 2'd0, 2'd0, 7'd11, 7'd56, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 below, R8 at
        '{1'b1, 8'h30, 2'd0, 2'd0, 7'd12, 7'd57, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 set, R8 below
        '{1'b1, 8'h30, 2'd0, 2'd0, 7'd3,  7'd57, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 hold
        '{1'b1, 8'h30, 2'd0, 2'd0, 7'd3,  7'd57, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 block
        '{1'b1, 8'h30, 2'd0, 2'd0, 7'd3,  7'd57, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 hold dropped
        '{1'b1, 8'h30, 2'd0, 2'd0, 7'd12, 7'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 rearm
        '{1'b1, 8'h30, 2'd0, 2'd0, 7'd0,  7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1}  // R7 drained
    };

    task automatic chk(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic drive(input vec_t v);
        dma_multi    = v.mode;
        trig_lvl_reg = v.trig;
        rx_dflt_sel  = v.rsel;
        tx_dflt_sel  = v.tsel;
        rx_count     = v.rc;
        tx_count     = v.tc;
        rx_err_flag  = v.err;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with inputs that would otherwise make both ready.
        rx_count = 7'd20;
        tx_count = 7'd0;
        repeat (3) @(negedge clk);
        chk("R1 rxrdy_n", rxrdy_n, 1);
        chk("R1 txrdy_n", txrdy_n, 1);
        chk("R1 rx_trig", rx_trig, 0);
        chk("R1 tx_trig", tx_trig, 0);
        chk("R1 rdy_status", rdy_status, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            chk($sformatf("R5/R7/R9 rxrdy_n v%0d", i), rxrdy_n, VEC[i].e_rxn);
            chk($sformatf("R6/R8 txrdy_n v%0d", i), txrdy_n, VEC[i].e_txn);
            chk($sformatf("R2/R4 rx_trig v%0d", i), rx_trig, VEC[i].e_rt);
            chk($sformatf("R3/R4 tx_trig v%0d", i), tx_trig, VEC[i].e_tt);
            chk($sformatf("R10 rdy_status v%0d", i), rdy_status,
                {~VEC[i].e_rxn, ~VEC[i].e_txn});
        end

        // R11: the state is rx empty, tx empty, block mode. Change inputs
        // between edges and confirm that nothing moves before the next edge.
        @(negedge clk);
        dma_multi = 1'b0;
        rx_count  = 7'd5;
        tx_count  = 7'd9;
        #1;
        chk("R11 rxrdy_n before edge", rxrdy_n, 1);
        chk("R11 txrdy_n before edge", txrdy_n, 0);
        @(negedge clk);
        chk("R11 rxrdy_n after edge", rxrdy_n, 0);
        chk("R11 txrdy_n after edge", txrdy_n, 1);

        // R1: a reset in mid-run clears the block hold.
        dma_multi    = 1'b1;
        trig_lvl_reg = 8'h30;
        rx_count     = 7'd12;
        @(negedge clk);
        chk("R7 armed before reset", rxrdy_n, 0);
        rst_n    = 1'b0;
        rx_count = 7'd3;
        @(negedge clk);
        chk("R1 mid-run rxrdy_n", rxrdy_n, 1);
        chk("R1 mid-run rdy_status", rdy_status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hold cleared by reset", rxrdy_n, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule